// File: doc/BRIEF.md
# Third-Order Error-Feedback Noise Shaper

This block sits between an oversampling interpolator and an external 15-cell current-steering converter. Each clock it takes one unsigned 10-bit sample and produces one 4-bit code. The quantization error from that code is shaped so that its spectrum follows (1 - z^-1)^3, which pushes the noise away from the low band. At an oversampling ratio of 16, the aim is an in-band signal-to-noise ratio above 70 dB.

The quantizer keeps the upper four bits of an internal sum. The remaining six bits form the error. That error goes through a three-tap delay line and is fed back with weights +3, -3 and +1 on the delays one, two and three samples back. The internal sum is wide enough that no intermediate value can overflow.

The 4-bit code is registered and then decoded into 15 thermometer lines, one line per unit cell. The input should stay roughly within 189..708: inside that window the output code never saturates and the loop stays stable. Outside it, the code is clamped to 0..15.

Top module: `efb_modulator`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the three error registers and the output code to zero. The first code after reset is released is therefore floor(x/64) for input x.
- R2: On each rising edge with rst low, the block forms s = x + 3*e1 - 3*e2 + e3 from the current input x and the stored errors e1, e2 and e3 (e1 is the newest). It registers floor(s/64) as codeOut, so the code appears one cycle after the input.
- R3: The error stored at each edge is s mod 64, the low six bits of s, always in 0..63. The older errors shift one place: e3 takes e2, and e2 takes e1.
- R4: When floor(s/64) is above 15 the code is 15. When it is below 0 the code is 0. The stored error is still s mod 64 in both cases.
- R5: thermOut bit k (k = 0..14) is 1 exactly when codeOut > k. This gives a thermometer pattern with codeOut ones, filled from bit 0 upward.
- R6: With a constant input x in the stable window, 64 times the sum of codeOut over 256 consecutive cycles differs from 256*x by at most 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one input and one output per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sampleIn | input | 10 | Unsigned oversampled input sample |
| codeOut | output | 4 | Registered noise-shaped code, 0..15 |
| thermOut | output | 15 | Thermometer decode of codeOut, bit k set when codeOut > k |

## Verification
The hardest conditions to reach from the ports are saturation and a reset that lands while the delay line holds nonzero errors. To reach saturation, the stimulus holds the input at full scale and then at zero for long stretches; during those stretches the loop keeps accumulating residues while the output stays clamped. To test the reset, it is pulsed in the middle of a busy sequence. The bench then confirms that the very next code is the plain truncation of the input. Triangle and ramp sequences move the loop through varied error histories, and long constant inputs test the average-value tracking.

// File: rtl/efb_pkg.sv
package efb_pkg;
  // Strobes from the control to the loop datapath
  typedef struct packed {
    logic clearErr;
    logic shiftErr;
  } loopCtl_t;
endpackage

// File: rtl/efb_ctrl.sv
module efb_ctrl
  import efb_pkg::*;
(
  input  logic     rst,
  output loopCtl_t ctl
);
  always_comb begin
    ctl.clearErr = rst;
    ctl.shiftErr = !rst;
  end
endmodule

// File: rtl/efb_loop.sv
module efb_loop
  import efb_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  loopCtl_t         ctl,
  input  logic [IN_W-1:0]  sampleIn,
  output logic [OUT_W-1:0] codeOut
);
  localparam int FRAC_W   = IN_W - OUT_W;
  localparam int SUM_W    = IN_W + 3;
  localparam int QW       = SUM_W - FRAC_W;
  localparam int CODE_MAX = (1 << OUT_W) - 1;
  localparam int ORDER    = 3;
  localparam logic signed [QW-1:0] Q_MAX = QW'(CODE_MAX);

  logic [FRAC_W-1:0]        errQ   [ORDER];
  logic signed [SUM_W-1:0]  errExt [ORDER];
  logic signed [SUM_W-1:0]  inExt, fbSum, loopSum;
  logic signed [QW-1:0]     qRaw;
  logic [FRAC_W-1:0]        resid;
  logic [OUT_W-1:0]         codeNext;
  logic                     overHi, underLo, inRange;

  for (genvar i = 0; i < ORDER; i++) begin : g_ext
    assign errExt[i] = signed'({{(SUM_W-FRAC_W){1'b0}}, errQ[i]});
  end

  assign inExt   = signed'({{(SUM_W-IN_W){1'b0}}, sampleIn});
  // Weights +3, -3, +1 built from shifts and adds
  assign fbSum   = (errExt[0] <<< 1) + errExt[0]
                 - (errExt[1] <<< 1) - errExt[1]
                 + errExt[2];
  assign loopSum = inExt + fbSum;
  assign qRaw    = loopSum[SUM_W-1:FRAC_W];
  assign resid   = loopSum[FRAC_W-1:0];

  assign underLo = qRaw[QW-1];
  assign overHi  = !underLo && (qRaw > Q_MAX);
  assign inRange = !underLo && !overHi;

  always_comb begin
    if (underLo)     codeNext = '0;
    else if (overHi) codeNext = OUT_W'(CODE_MAX);
    else             codeNext = qRaw[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctl.clearErr) begin
      codeOut <= '0;
      errQ[0] <= '0;
    end else if (ctl.shiftErr) begin
      codeOut <= codeNext;
      errQ[0] <= resid;
    end
  end

  for (genvar i = 1; i < ORDER; i++) begin : g_delay
    always_ff @(posedge clk) begin
      if (ctl.clearErr)      errQ[i] <= '0;
      else if (ctl.shiftErr) errQ[i] <= errQ[i-1];
    end
  end

  // R3: delay line moves one place per sample
  p_shift_r3: assert property (@(posedge clk) disable iff (ctl.clearErr)
    ctl.shiftErr |=> (errQ[1] == $past(errQ[0])) && (errQ[2] == $past(errQ[1])));

  // R2: unsaturated code and stored residue rebuild the sum
  p_recon_r2: assert property (@(posedge clk) disable iff (ctl.clearErr)
    (inRange && ctl.shiftErr) |=> ({codeOut, errQ[0]} == $past(loopSum[IN_W-1:0])));

  // R4: saturation at both ends
  p_clamp_hi_r4: assert property (@(posedge clk) disable iff (ctl.clearErr)
    (overHi && ctl.shiftErr) |=> (codeOut == OUT_W'(CODE_MAX)));
  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (ctl.clearErr)
    (underLo && ctl.shiftErr) |=> (codeOut == '0));
endmodule

// File: rtl/efb_therm.sv
module efb_therm #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0]             code,
  output logic [(1 << CODE_W) - 2:0]    therm
);
  localparam int LINES = (1 << CODE_W) - 1;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm[k] = (code > CODE_W'(k));
  end
endmodule

// File: rtl/efb_modulator.sv
module efb_modulator
  import efb_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int OUT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IN_W-1:0]           sampleIn,
  output logic [OUT_W-1:0]          codeOut,
  output logic [(1 << OUT_W) - 2:0] thermOut
);
  localparam int LINES = (1 << OUT_W) - 1;

  loopCtl_t loopCtl;

  efb_ctrl u_ctrl (
    .rst (rst),
    .ctl (loopCtl)
  );

  efb_loop #(.IN_W(IN_W), .OUT_W(OUT_W)) u_loop (
    .clk      (clk),
    .ctl      (loopCtl),
    .sampleIn (sampleIn),
    .codeOut  (codeOut)
  );

  efb_therm #(.CODE_W(OUT_W)) u_therm (
    .code  (codeOut),
    .therm (thermOut)
  );

  logic [LINES-1:0] thermInc;
  assign thermInc = thermOut + 1'b1;

  // R1: reset clears the output code
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (codeOut == '0) && (thermOut == '0));

  // R5: number of active lines equals the code
  p_therm_count_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(thermOut) == int'(codeOut));

  // R5: active lines are contiguous from line 0
  p_therm_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (thermInc & thermOut) == '0);
endmodule

// File: tb/efb_modulator_bench.sv
module efb_modulator_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] sampleIn = '0;
  logic [3:0] codeOut;
  logic [14:0] thermOut;

  int checks = 0;
  int errors = 0;
  int m1 = 0, m2 = 0, m3 = 0;
  longint codeAcc = 0;

  always #2 clk = ~clk;

  efb_modulator u_efb_modulator (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .codeOut  (codeOut),
    .thermOut (thermOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample through the behavioural loop model (R2, R3, R4, R5)
  task automatic step(input int x);
    int v, e, q, expCode, expTherm;
    sampleIn = 10'(x);
    v = x + 3 * m1 - 3 * m2 + m3;
    e = v & 63;
    q = (v - e) / 64;
    expCode = (q > 15) ? 15 : ((q < 0) ? 0 : q);
    expTherm = (1 << expCode) - 1;
    @(posedge clk);
    #1;
    check(int'(codeOut) == expCode, "R2/R3/R4 code", codeOut, expCode);
    check(int'(thermOut) == expTherm, "R5 therm", thermOut, expTherm);
    codeAcc += longint'(codeOut);
    m3 = m2; m2 = m1; m1 = e;
  endtask

  task automatic dcRun(input int x);
    longint diff;
    for (int i = 0; i < 32; i++) step(x);
    codeAcc = 0;
    for (int i = 0; i < 256; i++) step(x);
    diff = codeAcc * 64 - longint'(256 * x);
    if (diff < 0) diff = -diff;
    check(diff <= 512, "R6 dc mean", codeAcc * 64, 256 * x);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(codeOut == 4'd0, "R1 reset code", codeOut, 0);
    check(thermOut == 15'd0, "R1 reset therm", thermOut, 0);
    rst = 1'b0;

    // R1: first code after reset is plain truncation
    step(500);
    check(codeOut == 4'd7, "R1 first code", codeOut, 7);

    // Triangle sweep through the stable window
    for (int r = 0; r < 3; r++) begin
      for (int x = 200; x <= 700; x += 5) step(x);
      for (int x = 700; x >= 200; x -= 5) step(x);
    end

    // Slow ramp
    for (int x = 190; x <= 705; x++) step(x);

    // R4: saturation at full scale and at zero
    for (int i = 0; i < 60; i++) step(1023);
    check(codeOut == 4'd15, "R4 high clamp", codeOut, 15);
    for (int i = 0; i < 60; i++) step(0);
    check(codeOut == 4'd0, "R4 low clamp", codeOut, 0);
    for (int i = 0; i < 40; i++) step(512);

    // R1: reset with busy delay line
    for (int i = 0; i < 37; i++) step(333 + 7 * i);
    rst = 1'b1;
    sampleIn = 10'd700;
    @(posedge clk);
    #1;
    check(codeOut == 4'd0, "R1 mid reset code", codeOut, 0);
    check(thermOut == 15'd0, "R1 mid reset therm", thermOut, 0);
    m1 = 0; m2 = 0; m3 = 0;
    rst = 1'b0;
    step(700);
    check(codeOut == 4'd10, "R1 truncation after reset", codeOut, 10);

    // R6: mean tracks constant inputs
    dcRun(250);
    dcRun(512);
    dcRun(650);
    dcRun(431);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule